// File: doc/BRIEF.md
# Chip-Select Option Unit

This block drives one active-low external chip-select and a bus-cycle acknowledge pulse. Its inputs are a small set of option fields and the state of the current bus cycle. An address-decode result comes in as a single input. The block then qualifies the cycle by transfer direction and, when the 16-bit port option is on, by which byte lanes the access touches.

In asynchronous mode the select follows either the address strobe or the data strobe. Choosing the data strobe makes the output usable as a write strobe. In synchronous mode the select follows the E-clock high phase, which suits slow peripherals. A wait code either counts a programmed number of wait states before the internal acknowledge, ends the cycle early, or leaves termination to an external acknowledge. All select and acknowledge outputs are registered.

Top module: `csel_option_unit`

## Requirements
- R1: After reset, `cs_n` is 1 and `ack_o` is 0.
- R2: `dir_sel` gates the direction. Bit 0 set allows reads (`rd_nwr`=1) and bit 1 set allows writes (`rd_nwr`=0). With 00 the select never asserts.
- R3: With `port_wide`=1, a cycle qualifies only if the byte lanes it touches overlap the enabled lanes. `lane_sel` bit 0 enables the lower byte (`byte_lo`) and bit 1 enables the upper byte (`byte_hi`). With 00 nothing qualifies.
- R4: With `port_wide`=0, `lane_sel`, `byte_hi` and `byte_lo` have no effect on the select.
- R5: In asynchronous mode (`mode_sync`=0), the timing strobe is `as_i` when `strobe_ds`=0 and `ds_i` when `strobe_ds`=1. `cs_n` is low in the clock after each edge at which `addr_hit`, direction, lane and strobe all qualify, and high otherwise.
- R6: In synchronous mode (`mode_sync`=1), `eclk_i` takes the place of the strobe in the rule of R5, and `as_i`/`ds_i`/`strobe_ds` are ignored.
- R7: For `wait_code` n in 0..13, `ack_o` is high for exactly one clock. That clock follows the (n+2)-th consecutive qualifying edge, where the first qualifying edge is the one that starts the cycle.
- R8: `wait_code` 14 is fast termination. `ack_o` pulses in the same clock that `cs_n` first goes low, which is one clock ahead of code 0.
- R9: `wait_code` 15 hands termination to an external acknowledge, and `ack_o` stays 0.
- R10: The wait counter restarts at the start of every qualified cycle. If the cycle ends before the count is reached, no acknowledge is given. `ack_o` is only ever high while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sync | input | 1 | 0 asynchronous strobe timing, 1 E-clock timing |
| strobe_ds | input | 1 | Asynchronous mode: 0 address strobe, 1 data strobe |
| lane_sel | input | 2 | Enabled byte lanes (bit1 upper, bit0 lower) |
| dir_sel | input | 2 | Enabled directions (bit1 write, bit0 read) |
| wait_code | input | 4 | 0..13 wait states, 14 fast, 15 external |
| port_wide | input | 1 | 16-bit port option active |
| addr_hit | input | 1 | Address decode match for this select |
| rd_nwr | input | 1 | 1 read, 0 write |
| byte_hi | input | 1 | Access touches the upper byte |
| byte_lo | input | 1 | Access touches the lower byte |
| as_i | input | 1 | Address strobe, active high |
| ds_i | input | 1 | Data strobe, active high |
| eclk_i | input | 1 | E-clock level |
| cs_n | output | 1 | Chip-select, active low |
| ack_o | output | 1 | Internal acknowledge pulse |

## Verification
Directed cycles step through every direction code for both reads and writes, and every lane code with upper-only and lower-only accesses. This separates the qualifier bits from each other and shows the lane field being ignored when the wide port is off. The address strobe rises one clock ahead of the data strobe, so the select timing shows which strobe was chosen, and a synchronous run confirms the E-clock path. Every wait code from 0 to 15 is run with a long strobe to pin the acknowledge to its exact clock. Random cycles then mix all fields with short strobes that end before the count is reached, and they check both cancellation and the counter restart between back-to-back cycles.

// File: rtl/csel_option_unit.sv
module csel_option_unit #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic              strobe_ds,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        dir_sel,
  input  logic [CODE_W-1:0] wait_code,
  input  logic              port_wide,
  input  logic              addr_hit,
  input  logic              rd_nwr,
  input  logic              byte_hi,
  input  logic              byte_lo,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              eclk_i,
  output logic              cs_n,
  output logic              ack_o
);
  localparam logic [CODE_W-1:0] EXT_CODE  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] FAST_CODE = EXT_CODE - 1'b1;

  logic dir_ok, lane_ok, strobe, sel_now, start;
  logic sel_q, cs_q, ack_q, armed;
  logic [CODE_W-1:0] cnt;

  assign dir_ok  = (dir_sel[0] & rd_nwr) | (dir_sel[1] & ~rd_nwr);
  assign lane_ok = ~port_wide | (lane_sel[0] & byte_lo) | (lane_sel[1] & byte_hi);
  assign strobe  = mode_sync ? eclk_i : (strobe_ds ? ds_i : as_i);
  assign sel_now = addr_hit & dir_ok & lane_ok & strobe;
  assign start   = sel_now & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cs_q  <= 1'b0;
      ack_q <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      sel_q <= sel_now;
      cs_q  <= sel_now;
      ack_q <= 1'b0;
      if (!sel_now) begin
        armed <= 1'b0;
      end else if (start) begin
        ack_q <= (wait_code == FAST_CODE);
        armed <= (wait_code != FAST_CODE) && (wait_code != EXT_CODE);
        cnt   <= wait_code;
      end else if (armed) begin
        if (cnt == '0) begin
          ack_q <= (wait_code != EXT_CODE);
          armed <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign cs_n  = ~cs_q;
  assign ack_o = ack_q;

  // R2
  dir_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_sel == 2'b00) |=> cs_n);
  // R3
  lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wide && lane_sel == 2'b00) |=> cs_n);
  // R5
  as_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && !strobe_ds && !as_i) |=> cs_n);
  // R5
  ds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && strobe_ds && !ds_i) |=> cs_n);
  // R6
  eclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sync && !eclk_i) |=> cs_n);
  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  // R9
  ext_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_code == EXT_CODE) |=> !ack_o);
  // R10
  ack_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !cs_n);
endmodule

// File: tb/csel_option_unit_bench.sv
`timescale 1ns/1ps
module csel_option_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sync = 0, strobe_ds = 0, port_wide = 0, addr_hit = 0, rd_nwr = 0;
  logic byte_hi = 0, byte_lo = 0, as_i = 0, ds_i = 0, eclk_i = 0;
  logic [1:0] lane_sel = 0, dir_sel = 0;
  logic [3:0] wait_code = 0;
  logic cs_n, ack_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  csel_option_unit u_csel_option_unit (.*);

  function automatic bit qual_f();
    bit d, l;
    d = (dir_sel == 2'b11) || (dir_sel == 2'b01 && rd_nwr) || (dir_sel == 2'b10 && !rd_nwr);
    l = !port_wide || (lane_sel[0] && byte_lo) || (lane_sel[1] && byte_hi);
    return addr_hit && d && l;
  endfunction

  function automatic bit strobe_f();
    if (mode_sync) return eclk_i;
    return strobe_ds ? ds_i : as_i;
  endfunction

  function automatic bit ack_due(int run, logic [3:0] code);
    if (code == 4'd15) return 1'b0;
    if (code == 4'd14) return run == 1;
    return run == int'(code) + 2;
  endfunction

  task automatic chk(input string tag, input logic a_cs, a_ack, e_cs, e_ack);
    nchk++;
    if (a_cs !== e_cs || a_ack !== e_ack) begin
      nfail++;
      $display("FAIL %s: cs_n=%b ack_o=%b expected cs_n=%b ack_o=%b at %0t",
               tag, a_cs, a_ack, e_cs, e_ack, $time);
    end
  endtask

  task automatic drive_strobes(int j, int len);
    as_i   = (j >= 1 && j <= len);
    ds_i   = (j >= 2 && j <= len);
    eclk_i = (j >= 1 && j <= len);
  endtask

  task automatic trial(input string tag, input bit sy, sd, pw, hit, rd, hi, lo,
                       input logic [1:0] ln, dr, input logic [3:0] wc, input int len);
    int run = 0;
    bit sel;
    @(posedge clk); #1;
    mode_sync = sy; strobe_ds = sd; port_wide = pw; addr_hit = hit; rd_nwr = rd;
    byte_hi = hi; byte_lo = lo; lane_sel = ln; dir_sel = dr; wait_code = wc;
    drive_strobes(0, len);
    for (int j = 0; j < len + 4; j++) begin
      @(posedge clk);
      sel = qual_f() && strobe_f();
      run = sel ? run + 1 : 0;
      #1 drive_strobes(j + 1, len);
      @(negedge clk);
      chk(tag, cs_n, ack_o, !sel, sel && ack_due(run, wc));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", cs_n, ack_o, 1'b1, 1'b0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", cs_n, ack_o, 1'b1, 1'b0);

    // direction field: bit0 reads, bit1 writes
    trial("R2", 0, 0, 0, 1, 1, 1, 1, 2'b11, 2'b00, 4'd0, 5);
    trial("R2", 0, 0, 0, 1, 1, 1, 1, 2'b11, 2'b01, 4'd0, 5);
    trial("R2", 0, 0, 0, 1, 0, 1, 1, 2'b11, 2'b01, 4'd0, 5);
    trial("R2", 0, 0, 0, 1, 0, 1, 1, 2'b11, 2'b10, 4'd0, 5);
    trial("R2", 0, 0, 0, 1, 1, 1, 1, 2'b11, 2'b10, 4'd0, 5);
    trial("R2", 0, 0, 0, 1, 0, 1, 1, 2'b11, 2'b11, 4'd1, 5);
    // lane field with wide port
    trial("R3", 0, 0, 1, 1, 1, 1, 0, 2'b01, 2'b11, 4'd0, 5);
    trial("R3", 0, 0, 1, 1, 1, 1, 0, 2'b10, 2'b11, 4'd0, 5);
    trial("R3", 0, 0, 1, 1, 1, 0, 1, 2'b01, 2'b11, 4'd0, 5);
    trial("R3", 0, 0, 1, 1, 1, 1, 1, 2'b00, 2'b11, 4'd0, 5);
    // lane field ignored with narrow port
    trial("R4", 0, 0, 0, 1, 1, 1, 0, 2'b00, 2'b11, 4'd0, 5);
    trial("R4", 0, 0, 0, 1, 1, 0, 0, 2'b01, 2'b11, 4'd2, 5);
    // strobe choice and sync mode
    trial("R5", 0, 1, 0, 1, 0, 1, 1, 2'b11, 2'b11, 4'd1, 6);
    trial("R5", 0, 0, 0, 1, 0, 1, 1, 2'b11, 2'b11, 4'd1, 6);
    trial("R5", 0, 1, 0, 1, 0, 1, 1, 2'b11, 2'b11, 4'd0, 1);
    trial("R6", 1, 1, 0, 1, 1, 1, 1, 2'b11, 2'b11, 4'd3, 7);
    // every wait code with a long cycle
    for (int c = 0; c < 14; c++)
      trial("R7", 0, 0, 0, 1, 1, 1, 1, 2'b11, 2'b11, 4'(c), 18);
    trial("R8", 0, 0, 0, 1, 1, 1, 1, 2'b11, 2'b11, 4'd14, 6);
    trial("R8", 1, 0, 0, 1, 0, 1, 1, 2'b11, 2'b11, 4'd14, 3);
    trial("R9", 0, 0, 0, 1, 1, 1, 1, 2'b11, 2'b11, 4'd15, 20);
    // cycle ending before the count
    trial("R10", 0, 0, 0, 1, 1, 1, 1, 2'b11, 2'b11, 4'd9, 4);
    trial("R10", 0, 0, 0, 1, 1, 1, 1, 2'b11, 2'b11, 4'd2, 6);

    for (int k = 0; k < 300; k++)
      trial("R10", 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) != 0,
            1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
            4'($urandom), 1 + int'($urandom % 18));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule